// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock for a SPI-style shifter from a faster module clock. Two divide schemes are available and a single mode bit picks one. The power-of-two scheme divides by 2^n, where n is the exponent field itself. The linear scheme divides by 2*(n+1), where n is an 8-bit field. Any rate slower than the largest linear divide must use the power-of-two scheme.

Along with the serial clock level, the block drives two one-cycle strobes that mark the rising and falling serial clock edges. A shifter can use these strobes to launch and capture data on the module clock, with no second clock domain.

While the transfer enable is low, the serial clock rests at a programmable idle level. During that time the divider also takes in the mode and divisor settings. Once the enable is high those settings are frozen, so a change written mid-transfer waits until the transfer ends. The first serial edge comes a full half-period after the enable rises, so the output never has a short pulse.

Top module: `sclk_divgen`

## Requirements
- R1: With `lin_sel`=0 and `pow_exp`=n≥1, each serial clock level lasts 2^(n-1) module cycles, which gives a period of 2^n cycles.
- R2: With `lin_sel`=0 and `pow_exp`=0, the serial clock toggles on every enabled module clock edge. The strobe fires every cycle, alternating between rising and falling. This output is the same as for `pow_exp`=1.
- R3: With `lin_sel`=1 and `lin_div`=n, each serial clock level lasts n+1 module cycles, which gives a period of 2*(n+1) cycles. This holds from n=0 up to n=255.
- R4: For every setting, the high and low phases of the serial clock have equal length, at H = half the divide ratio.
- R5: Count the rising module clock edges at which `xfer_en` is sampled high, starting from the first one. The first serial edge happens on edge number H, and each later edge comes H edges after the one before. The first serial edge moves the clock away from the idle level.
- R6: At each edge where `xfer_en` is sampled low, `sclk` takes the value of `idle_pol` and both strobes go to 0.
- R7: `sclk_rise` is 1 for exactly the one cycle in which `sclk` has just gone from 0 to 1. `sclk_fall` is 1 for exactly the one cycle in which `sclk` has just gone from 1 to 0. The two strobes are never 1 together.
- R8: The settings `lin_sel`, `pow_exp` and `lin_div` are captured at every edge where `xfer_en` is low. Changes made while `xfer_en` is high have no effect on the running serial clock.
- R9: While `rst` is sampled high, `sclk` follows `idle_pol` and both strobes are 0. After reset, a new transfer starts its timing from zero, as R5 describes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_en | input | 1 | Transfer active; the serial clock runs while this is high |
| lin_sel | input | 1 | 1 selects the linear divide, 0 selects the power-of-two divide |
| pow_exp | input | POW_W (4) | Power-of-two exponent n; ratio is 2^n |
| lin_div | input | LIN_W (8) | Linear divisor n; ratio is 2*(n+1) |
| idle_pol | input | 1 | Serial clock level while no transfer runs |
| sclk | output | 1 | Serial clock level (registered) |
| sclk_rise | output | 1 | One-cycle strobe on a 0-to-1 serial edge |
| sclk_fall | output | 1 | One-cycle strobe on a 1-to-0 serial edge |

## Verification
The assertions assume that `idle_pol` does not change while reset is held. They also assume the divisor settings are valid at the last idle edge before a transfer, because those are the values the block freezes. The stimulus meets both conditions. It changes the divisors and the polarity only on falling module clock edges, and only while the enable is low. It then waits at least one idle cycle before it raises the enable. While a transfer runs, the bench deliberately scrambles the mode bit and both divisor fields on every cycle, and still expects timing that follows the settings captured before the transfer began.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  typedef enum logic {
    DIV_POW2 = 1'b0,
    DIV_LIN  = 1'b1
  } div_mode_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold
  import sclk_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_en,
  input  logic             lin_sel,
  input  logic [POW_W-1:0] pow_exp,
  input  logic [LIN_W-1:0] lin_div,
  output div_mode_e        mode_q,
  output logic [POW_W-1:0] pow_q,
  output logic [LIN_W-1:0] lin_q
);

  // Settings follow the inputs only while idle; frozen during a transfer.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= DIV_POW2;
      pow_q  <= '0;
      lin_q  <= '0;
    end else if (!xfer_en) begin
      mode_q <= lin_sel ? DIV_LIN : DIV_POW2;
      pow_q  <= pow_exp;
      lin_q  <= lin_div;
    end
  end

endmodule

// File: rtl/sclk_half_len.sv
module sclk_half_len
  import sclk_div_pkg::*;
#(
  parameter int LIN_W  = 8,
  parameter int POW_W  = 4,
  parameter int HALF_W = 15
) (
  input  div_mode_e         mode,
  input  logic [POW_W-1:0]  pow_exp,
  input  logic [LIN_W-1:0]  lin_div,
  output logic [HALF_W-1:0] half_len
);

  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  logic [HALF_W-1:0] pow_half;
  logic [HALF_W-1:0] lin_half;

  // Ratio 2^n -> half 2^(n-1); n=0 cannot be split, so it runs as ratio 2.
  always_comb begin
    if (pow_exp == '0) pow_half = ONE;
    else               pow_half = ONE << (pow_exp - POW_W'(1));
  end

  // Ratio 2*(n+1) -> half n+1.
  assign lin_half = HALF_W'(lin_div) + ONE;

  assign half_len = (mode == DIV_LIN) ? lin_half : pow_half;

endmodule

// File: rtl/sclk_phase_cnt.sv
module sclk_phase_cnt #(
  parameter int HALF_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half_len,
  output logic              tick
);

  logic [HALF_W-1:0] cnt;

  assign tick = run && (cnt == half_len - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + HALF_W'(1);
  end

endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic idle_pol,
  input  logic tick,
  output logic sclk,
  output logic sclk_rise,
  output logic sclk_fall
);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sclk      <= idle_pol;
      sclk_rise <= 1'b0;
      sclk_fall <= 1'b0;
    end else if (tick) begin
      sclk      <= ~sclk;
      sclk_rise <= ~sclk;
      sclk_fall <= sclk;
    end else begin
      sclk_rise <= 1'b0;
      sclk_fall <= 1'b0;
    end
  end

endmodule

// File: rtl/sclk_divgen.sv
module sclk_divgen
  import sclk_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_en,
  input  logic             lin_sel,
  input  logic [POW_W-1:0] pow_exp,
  input  logic [LIN_W-1:0] lin_div,
  input  logic             idle_pol,
  output logic             sclk,
  output logic             sclk_rise,
  output logic             sclk_fall
);

  localparam int POW_HALF_W = (1 << POW_W) - 1;
  localparam int LIN_HALF_W = LIN_W + 1;
  localparam int HALF_W     = max_int(POW_HALF_W, LIN_HALF_W);

  div_mode_e         mode_q;
  logic [POW_W-1:0]  pow_q;
  logic [LIN_W-1:0]  lin_q;
  logic [HALF_W-1:0] half_len;
  logic              tick;

  sclk_cfg_hold #(.LIN_W(LIN_W), .POW_W(POW_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .xfer_en (xfer_en),
    .lin_sel (lin_sel),
    .pow_exp (pow_exp),
    .lin_div (lin_div),
    .mode_q  (mode_q),
    .pow_q   (pow_q),
    .lin_q   (lin_q)
  );

  sclk_half_len #(.LIN_W(LIN_W), .POW_W(POW_W), .HALF_W(HALF_W)) u_len (
    .mode     (mode_q),
    .pow_exp  (pow_q),
    .lin_div  (lin_q),
    .half_len (half_len)
  );

  sclk_phase_cnt #(.HALF_W(HALF_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run      (xfer_en),
    .half_len (half_len),
    .tick     (tick)
  );

  sclk_edge_gen u_edge (
    .clk       (clk),
    .rst       (rst),
    .run       (xfer_en),
    .idle_pol  (idle_pol),
    .tick      (tick),
    .sclk      (sclk),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

endmodule

// File: rtl/sclk_divgen_chk.sv
module sclk_divgen_chk
  import sclk_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             xfer_en,
  input logic             idle_pol,
  input logic             sclk,
  input logic             sclk_rise,
  input logic             sclk_fall,
  input div_mode_e        mode_q,
  input logic [POW_W-1:0] pow_q,
  input logic [LIN_W-1:0] lin_q
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sclk_rise && sclk_fall)); // R7

  AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !$past(rst)) |-> (sclk && !$past(sclk))); // R7

  AST_FALL_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (sclk_fall && !$past(rst)) |-> (!sclk && $past(sclk))); // R7

  AST_TOGGLE_STROBED: assert property (@(posedge clk) disable iff (rst)
    ($past(xfer_en) && !$past(rst) && (sclk != $past(sclk))) |-> (sclk_rise || sclk_fall)); // R5

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !xfer_en |=> ((sclk == $past(idle_pol)) && !sclk_rise && !sclk_fall)); // R6

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && $past(xfer_en) && !$past(rst)) |->
      ($stable(mode_q) && $stable(pow_q) && $stable(lin_q))); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!sclk_rise && !sclk_fall)); // R9

endmodule

bind sclk_divgen sclk_divgen_chk #(.LIN_W(LIN_W), .POW_W(POW_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .xfer_en   (xfer_en),
  .idle_pol  (idle_pol),
  .sclk      (sclk),
  .sclk_rise (sclk_rise),
  .sclk_fall (sclk_fall),
  .mode_q    (mode_q),
  .pow_q     (pow_q),
  .lin_q     (lin_q)
);

// File: tb/sclk_divgen_tb.sv
module sclk_divgen_tb;

  localparam int LIN_W = 8;
  localparam int POW_W = 4;
  localparam int WATCHDOG_CYCLES = 150000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             xfer_en = 1'b0;
  logic             lin_sel = 1'b0;
  logic [POW_W-1:0] pow_exp = '0;
  logic [LIN_W-1:0] lin_div = '0;
  logic             idle_pol = 1'b0;
  logic             sclk, sclk_rise, sclk_fall;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sclk_divgen #(.LIN_W(LIN_W), .POW_W(POW_W)) u_dut (
    .clk (clk), .rst (rst), .xfer_en (xfer_en), .lin_sel (lin_sel),
    .pow_exp (pow_exp), .lin_div (lin_div), .idle_pol (idle_pol),
    .sclk (sclk), .sclk_rise (sclk_rise), .sclk_fall (sclk_fall)
  );

  // Half-period in module cycles, from R1/R2/R3.
  function automatic int half_of(input bit lin, input int pexp, input int ldiv);
    if (lin)       return ldiv + 1;
    if (pexp == 0) return 1;
    return 1 << (pexp - 1);
  endfunction

  task automatic check(input string req, input logic s, input logic r, input logic f,
                       input logic es, input logic er, input logic ef);
    n_checks++;
    if (s !== es || r !== er || f !== ef) begin
      n_fail++;
      $display("FAIL %s: sclk/rise/fall got %b%b%b expected %b%b%b at %0t",
               req, s, r, f, es, er, ef, $time);
    end
  endtask

  // One transfer: settings applied while idle, then scrambled during the run (R8).
  task automatic run_xfer(input string req, input bit lin, input int pexp, input int ldiv,
                          input bit pol, input int ncyc, input bit scramble);
    int h;
    bit es;
    h = half_of(lin, pexp, ldiv);
    @(negedge clk);
    lin_sel = lin; pow_exp = POW_W'(pexp); lin_div = LIN_W'(ldiv); idle_pol = pol;
    @(posedge clk); #1;
    check({req, " R6 idle"}, sclk, sclk_rise, sclk_fall, pol, 1'b0, 1'b0);
    @(negedge clk);
    xfer_en = 1'b1;
    for (int j = 1; j <= ncyc; j++) begin
      @(posedge clk); #1;
      es = pol ^ (((j / h) % 2) == 1);
      if (j % h == 0)
        check({req, " R4 R5 edge"}, sclk, sclk_rise, sclk_fall, es, es, !es);
      else
        check({req, " R4 R5 hold"}, sclk, sclk_rise, sclk_fall, es, 1'b0, 1'b0);
      @(negedge clk);
      if (scramble) begin
        lin_sel = 1'($urandom);
        pow_exp = POW_W'($urandom);
        lin_div = LIN_W'($urandom);
      end
    end
    xfer_en = 1'b0;
    @(posedge clk); #1;
    check({req, " R6 stop"}, sclk, sclk_rise, sclk_fall, pol, 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset", sclk, sclk_rise, sclk_fall, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    run_xfer("R2 pow n=0", 1'b0, 0, 0, 1'b0, 12, 1'b0);
    run_xfer("R2 pow n=1", 1'b0, 1, 0, 1'b1, 12, 1'b0);
    run_xfer("R1 pow n=3", 1'b0, 3, 0, 1'b0, 40, 1'b1);
    run_xfer("R1 pow n=15", 1'b0, 15, 0, 1'b0, 2 * 16384 + 3, 1'b0);
    run_xfer("R3 lin n=0", 1'b1, 0, 0, 1'b0, 10, 1'b1);
    run_xfer("R3 lin n=255", 1'b1, 0, 255, 1'b1, 2 * 256 + 3, 1'b1);
    run_xfer("R3 lin n=5", 1'b1, 0, 5, 1'b1, 50, 1'b0);

    // R9: reset mid-transfer, then a fresh transfer restarts its timing.
    @(negedge clk);
    lin_sel = 1'b1; lin_div = 8'd3; idle_pol = 1'b1;
    @(negedge clk);
    xfer_en = 1'b1;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R9 mid reset", sclk, sclk_rise, sclk_fall, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    xfer_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    run_xfer("R9 after reset", 1'b1, 0, 3, 1'b1, 20, 1'b0);

    for (int t = 0; t < 24; t++) begin
      bit lin, pol;
      int pexp, ldiv, h;
      lin  = 1'($urandom);
      pol  = 1'($urandom);
      pexp = int'($urandom % 10);
      ldiv = int'($urandom % 256);
      h    = half_of(lin, pexp, ldiv);
      run_xfer(lin ? "R3 R8 rand" : "R1 R8 rand", lin, pexp, ldiv, pol,
               2 * h + 1 + int'($urandom % (h + 1)), 1'b1);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run incomplete, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule